// File: doc/BRIEF.md
# Host Interrupt Enable and Clear Controller

This block merges four interrupt sources into one active-low, level-sensitive interrupt line towards the host bus. Three sources are events: a pulse from the host-side comport input register when the attached processor has loaded it, a pulse when the host-side comport output register has sent its contents, and a programmed request pulse from the processor. Each event is caught in a local flag that stays set until the host clears it. The fourth source is a level from a test bus controller. It is not latched here, and it drops only when every cause inside that controller has been serviced.

The host sees one register address. A write there loads the four enable bits and fires write-one-to-clear strobes for the three latched flags. A read there returns the enables in the low nibble and the source states in the high nibble, in the bit positions used by the clear strobes. Writing the read value straight back therefore acknowledges every pending event at once and leaves the enables as they were. Enables only gate the interrupt line. An event still latches while its enable is 0.

Top module: `hirq_ctrl`

## Requirements
- R1: After synchronous reset (`rst`=1 at a clock edge), all enables and all latched flags are 0, `host_irq_n` is 1 unless the test bus level is enabled, and a read of the register returns 0 in bits 0..5 and 7.
- R2: A write (`bus_wr`=1) with `bus_addr`=0x18 loads `bus_wdata[3:0]` into the enables at the next edge. Bit 0 is the output-empty enable, bit 1 the input-full enable, bit 2 the test bus enable and bit 3 the processor enable. A write to any other address changes nothing.
- R3: A one-cycle pulse on `obe_evt`, `ibf_evt` or `cpu_evt` sets the matching flag at the next edge, whatever its enable.
- R4: A write to 0x18 with 1 in bit 4, 5 or 7 clears the output-empty, input-full or processor flag respectively. A 0 in those bits leaves the flag unchanged.
- R5: When a set pulse and its clear strobe occur in the same cycle, the flag ends up set.
- R6: Bit 6 of a write has no effect. It neither clears nor masks the test bus level.
- R7: `tbc_lvl` is not stored. Status bit 6 and its share of the interrupt follow the input in the same cycle.
- R8: `host_irq_n` is 0 exactly when some source state is 1 and its enable is 1. Otherwise it is 1.
- R9: A read with `bus_addr`=0x18 returns {processor flag, test bus level, input-full flag, output-empty flag, enables[3:0]} from bit 7 down to bit 0. Any other address returns 0.
- R10: Writing the returned status byte back to 0x18 clears every pending latched flag and keeps the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (status when address hits) |
| obe_evt | input | 1 | Output register emptied, one-cycle pulse |
| ibf_evt | input | 1 | Input register loaded, one-cycle pulse |
| tbc_lvl | input | 1 | Test bus controller interrupt level |
| cpu_evt | input | 1 | Processor programmed request, one-cycle pulse |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
The bench targets a set pulse that arrives in the same cycle as its clear strobe. A design that gave the clear priority would lose that event and leave the line high. It writes bit 6 while the test bus level is high and enabled, which catches a design that latches or masks that source. It also raises events while the enables are 0 and then enables them, so gating applied at the latch input would show up as a missing interrupt. The status write-back and writes to a neighbouring address check that enables are not disturbed and that acknowledges do not leak.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    // Source index; clear strobe / status flag bit is index + NSRC
    localparam int NSRC    = 4;
    localparam int SRC_OBE = 0;
    localparam int SRC_IBF = 1;
    localparam int SRC_TBC = 2;
    localparam int SRC_CPU = 3;
    // Sources captured locally (1) versus passed through as a level (0)
    localparam logic [NSRC-1:0] LATCH_MASK = 4'b1011;
endpackage

// File: rtl/hirq_evt_latch.sv
module hirq_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R3 R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/hirq_regif.sv
module hirq_regif #(
    parameter int          ADDR_W    = 8,
    parameter int          NSRC      = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18,
    localparam int         DATA_W    = 2 * NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NSRC-1:0]   stat_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic addr_hit;
    logic wr_hit;

    assign addr_hit = (bus_addr == CTRL_ADDR);
    assign wr_hit   = addr_hit && bus_wr;

    always_ff @(posedge clk) begin
        if (rst)
            en_o <= '0;
        else if (wr_hit)
            en_o <= bus_wdata[NSRC-1:0];
    end

    always_comb begin
        clr_o   = wr_hit ? bus_wdata[DATA_W-1:NSRC] : '0;
        rdata_o = addr_hit ? {stat_i, en_o} : '0;
    end

    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (en_o == $past(bus_wdata[NSRC-1:0])));
    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(en_o));
    // R9
    rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_hit |-> (rdata_o == '0));
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
    import hirq_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18,
    localparam int              DATA_W    = 2 * NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              obe_evt,
    input  logic              ibf_evt,
    input  logic              tbc_lvl,
    input  logic              cpu_evt,
    output logic              host_irq_n
);
    logic [NSRC-1:0] src_w;
    logic [NSRC-1:0] stat_w;
    logic [NSRC-1:0] en_w;
    logic [NSRC-1:0] clr_w;

    always_comb begin
        src_w          = '0;
        src_w[SRC_OBE] = obe_evt;
        src_w[SRC_IBF] = ibf_evt;
        src_w[SRC_TBC] = tbc_lvl;
        src_w[SRC_CPU] = cpu_evt;
    end

    hirq_regif #(
        .ADDR_W    (ADDR_W),
        .NSRC      (NSRC),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_i    (stat_w),
        .en_o      (en_w),
        .clr_o     (clr_w),
        .rdata_o   (bus_rdata)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (LATCH_MASK[i]) begin : g_latch
            hirq_evt_latch u_latch (
                .clk    (clk),
                .rst    (rst),
                .set_i  (src_w[i]),
                .clr_i  (clr_w[i]),
                .flag_o (stat_w[i])
            );
        end else begin : g_level
            assign stat_w[i] = src_w[i];
            // R6 R7
            level_path_chk: assert property (@(posedge clk) disable iff (rst)
                (src_w[i] && en_w[i] && (clr_w[i] || !clr_w[i])) |-> !host_irq_n);
        end
    end

    assign host_irq_n = ~|(stat_w & en_w);

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en_w == '0) |-> host_irq_n);
endmodule

// File: tb/hirq_ctrl_bench.sv
module hirq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       obe_evt, ibf_evt, tbc_lvl, cpu_evt;
    logic       host_irq_n;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag    = "R1";

    // behavioural reference state
    bit [3:0] m_en;
    bit       m_obe, m_ibf, m_cpu;

    always #10 clk = ~clk;

    hirq_ctrl u_hirq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .obe_evt    (obe_evt),
        .ibf_evt    (ibf_evt),
        .tbc_lvl    (tbc_lvl),
        .cpu_evt    (cpu_evt),
        .host_irq_n (host_irq_n)
    );

    function automatic bit [7:0] m_status();
        return {m_cpu, tbc_lvl, m_ibf, m_obe, m_en};
    endfunction

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare combinational outputs, advance the model
    task automatic cyc(input bit wr, input bit [7:0] addr, input bit [7:0] wd,
                       input bit po, input bit pi, input bit pc);
        bit hit;
        bit irq;
        bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        obe_evt = po; ibf_evt = pi; cpu_evt = pc;
        #1;
        irq = (m_obe && m_en[0]) || (m_ibf && m_en[1]) ||
              (tbc_lvl && m_en[2]) || (m_cpu && m_en[3]);
        check("host_irq_n", int'(host_irq_n), int'(!irq));
        check("bus_rdata", int'(bus_rdata), (addr == 8'h18) ? int'(m_status()) : 0);
        @(posedge clk);
        if (rst) begin
            m_en = '0; m_obe = 0; m_ibf = 0; m_cpu = 0;
        end else begin
            hit   = wr && (addr == 8'h18);
            m_obe = po || (m_obe && !(hit && wd[4]));
            m_ibf = pi || (m_ibf && !(hit && wd[5]));
            m_cpu = pc || (m_cpu && !(hit && wd[7]));
            if (hit) m_en = wd[3:0];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 8'h18, 8'h00, 0, 0, 0);
    endtask

    initial begin
        bit [7:0] lfsr;
        bit [7:0] sb;
        rst = 1; tbc_lvl = 0;
        bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        obe_evt = 0; ibf_evt = 0; cpu_evt = 0;
        m_en = 4'hF; m_obe = 1; m_ibf = 1; m_cpu = 1;
        @(negedge clk);
        @(posedge clk); m_en = '0; m_obe = 0; m_ibf = 0; m_cpu = 0;
        @(negedge clk);
        cyc(0, 8'h18, 8'h00, 0, 0, 0);
        rst = 0;
        tag = "R1"; idle(2);

        // R2: load enables, then an off-address write is ignored
        tag = "R2"; cyc(1, 8'h18, 8'h05, 0, 0, 0); idle(1);
        cyc(1, 8'h19, 8'h0A, 0, 0, 0); cyc(1, 8'h10, 8'hFF, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h00, 0, 0, 0); idle(1);

        // R3: events latch while disabled, no interrupt
        tag = "R3"; cyc(0, 8'h00, 8'h00, 1, 0, 0); cyc(0, 8'h00, 8'h00, 0, 1, 0);
        cyc(0, 8'h00, 8'h00, 0, 0, 1); idle(2);
        // R9: read the status layout, and a miss returns 0
        tag = "R9"; cyc(0, 8'h18, 8'h00, 0, 0, 0); cyc(0, 8'h08, 8'h00, 0, 0, 0);
        // R8: enabling each source in turn drives the line
        tag = "R8";
        cyc(1, 8'h18, 8'h01, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h02, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h08, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h0B, 0, 0, 0); idle(1);

        // R4: zero clear bits do nothing, then clear one at a time
        tag = "R4"; cyc(1, 8'h18, 8'h0B, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h1B, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h2B, 0, 0, 0); idle(1);
        cyc(1, 8'h18, 8'h8B, 0, 0, 0); idle(1);

        // R5: set and clear collide
        tag = "R5"; cyc(1, 8'h18, 8'hBB, 1, 1, 1); idle(2);
        cyc(1, 8'h18, 8'hB0, 0, 0, 0); idle(1);

        // R7: level passes straight through, not held
        tag = "R7"; cyc(1, 8'h18, 8'h04, 0, 0, 0);
        tbc_lvl = 1; idle(2); tbc_lvl = 0; idle(1); tbc_lvl = 1; idle(1);
        // R6: bit 6 neither clears nor masks the level
        tag = "R6"; cyc(1, 8'h18, 8'h44, 0, 0, 0); idle(2);
        cyc(1, 8'h18, 8'hF4, 0, 0, 0); idle(1);
        tbc_lvl = 0; idle(1);

        // R10: status write-back acknowledges all and keeps enables
        tag = "R10"; cyc(1, 8'h18, 8'h0D, 1, 1, 1); tbc_lvl = 1; idle(1);
        sb = m_status();
        cyc(1, 8'h18, sb, 0, 0, 0); idle(2);
        tbc_lvl = 0; idle(1);

        // R8: pseudo-random mix of writes and events
        tag = "R8"; lfsr = 8'hA5;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tbc_lvl = lfsr[6];
            cyc(lfsr[0] && lfsr[1], lfsr[2] ? 8'h18 : 8'h1C,
                {lfsr[3:0], lfsr[7:4]}, lfsr[4], lfsr[5], lfsr[7] && lfsr[2]);
        end

        // R1: reset in the middle of activity
        tag = "R1"; tbc_lvl = 0; rst = 1; cyc(0, 8'h18, 8'h00, 0, 0, 0);
        rst = 0; idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule